// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge with CPU Wait

This block sits between a 16-bit processor bus and an 8-bit external bus. Every processor access is a full 16-bit word. When the word address falls outside the fast regions, the bridge splits the access into two byte cycles on the external bus. The low byte goes first, with the external address bit 0 forced to 1. The high byte goes second, with bit 0 forced to 0. The processor is held in wait from the cycle of its request until both byte cycles have finished. On reads, the first byte is kept in the low half of a holding register, and the full word is returned only once the second byte has arrived.

An address decoder in front of the sequencer steers some accesses to a fast port instead of the bridge. These are the on-chip monitor ROM, the on-chip scratch RAM and, when the fast-RAM mode input is high, two expansion windows. Fast accesses complete in the cycle they are presented, with no wait and no external strobe.

Handshake rules: the processor raises `cpu_valid` and keeps the request presented. An access completes on a cycle in which `cpu_valid` is high and `cpu_wait` is low; `cpu_wait` is the only back-pressure. The processor drops `cpu_valid` or presents the next access on the cycle after completion. Address, write data and direction are captured when a bridged access starts, so the processor bus may change while it waits.

Top module: `wide_narrow_bridge`

## Requirements
- R1: A bridged read runs two byte cycles and returns `cpu_rdata` = {second byte, first byte}. The first byte is read at external address {cpu_addr[15:1],1} and the second at {cpu_addr[15:1],0}.
- R2: A bridged write drives `ext_wdata` = cpu_wdata[7:0] with `ext_wr` high during the first byte cycle, then cpu_wdata[15:8] during the second.
- R3: During a bridged access `ext_addr[15:1]` equals the captured cpu_addr[15:1]. `ext_addr[0]` is 1 in the first byte cycle and 0 in the second. `ext_addr` is 0 when no byte cycle runs.
- R4: Each byte cycle keeps its strobe (`ext_rd` for reads, `ext_wr` for writes) high for exactly BYTE_CLKS clocks, and the two byte cycles follow back to back. `ext_rdata` is sampled on the last clock of each cycle. `ext_rd` and `ext_wr` are never high together.
- R5: For a bridged access presented in cycle 0, `cpu_wait` is high in cycles 0 to 2*BYTE_CLKS and low in cycle 2*BYTE_CLKS+1, which is the completion cycle.
- R6: Word addresses 0x0000–0x1FFF (monitor ROM) are fast. They give `fast_sel`=1 and `cpu_rdata`=`fast_rdata` in the same cycle, with no wait and no external strobe. `fast_we` = `cpu_we` for every fast region.
- R7: Addresses RAM_BASE to RAM_BASE+255 (default 0x8300–0x83FF, scratch RAM) are fast with `fast_sel`=2, in the same way as R6.
- R8: With `fast_en`=1, addresses 0x2000–0x3FFF and 0xA000–0xFFFF are fast with `fast_sel`=3. With `fast_en`=0 they are bridged. `fast_sel`=0 whenever no fast access is presented.
- R9: Changing `cpu_addr`, `cpu_wdata` or `cpu_we` after the first cycle of a bridged access has no effect on that access's external address, write data, strobes or returned data.
- R10: Synchronous reset returns the sequencer to idle. In the cycle after reset `ext_rd`, `ext_wr` and `cpu_wait` are low if no access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_en | input | 1 | Enables the fast-RAM expansion windows |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address of the word |
| cpu_wdata | input | 16 | Processor write word |
| cpu_wait | output | 1 | Holds the processor until the access completes |
| cpu_rdata | output | 16 | Read word, valid in the completion cycle |
| fast_sel | output | 2 | Fast region: 0 none, 1 ROM, 2 scratch RAM, 3 fast RAM |
| fast_we | output | 1 | Write strobe to the selected fast memory |
| fast_rdata | input | 16 | Read word from the selected fast memory |
| ext_addr | output | 16 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_rdata | input | 8 | External read byte |

## Verification
A wrong phase or lane state shows at once on `ext_addr[0]` or on the byte placed on `ext_wdata`, in the first clock of the affected byte cycle. A cycle counter that is off by one changes the strobe length and moves the fall of `cpu_wait` by at least one cycle within 2*BYTE_CLKS+1 cycles of the request. A bad holding register or a bad capture shows as a wrong `cpu_rdata` in the completion cycle. A decoder fault shows as a wait or a strobe in the first cycle of what should be a fast access, or as a missing one on a bridged access.

// File: rtl/wnb_pkg.sv
package wnb_pkg;
  typedef enum logic [1:0] {
    REG_EXT  = 2'd0,
    REG_ROM  = 2'd1,
    REG_RAM  = 2'd2,
    REG_FAST = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/wnb_decode.sv
module wnb_decode
  import wnb_pkg::*;
#(
  parameter int AW            = 16,
  parameter int ROM_BYTES     = 8192,
  parameter int RAM_BASE      = 'h8300,
  parameter int RAM_BYTES     = 256,
  parameter bit HAS_FAST      = 1'b1,
  parameter int FAST_LO_START = 'h2000,
  parameter int FAST_LO_LAST  = 'h3FFF,
  parameter int FAST_HI_START = 'hA000
) (
  input  logic [AW-1:0] addr,
  input  logic          fast_en,
  output region_e       region
);
  localparam logic [AW:0] ROM_LIM  = (AW+1)'(ROM_BYTES);
  localparam logic [AW:0] RAM_LO   = (AW+1)'(RAM_BASE);
  localparam logic [AW:0] RAM_LIM  = (AW+1)'(RAM_BASE + RAM_BYTES);
  localparam logic [AW:0] FLO_LO   = (AW+1)'(FAST_LO_START);
  localparam logic [AW:0] FLO_HI   = (AW+1)'(FAST_LO_LAST);
  localparam logic [AW:0] FHI_LO   = (AW+1)'(FAST_HI_START);

  logic [AW:0] a_x;
  logic        in_rom, in_ram, in_fast;

  assign a_x    = {1'b0, addr};
  assign in_rom = (a_x < ROM_LIM);
  assign in_ram = (a_x >= RAM_LO) && (a_x < RAM_LIM);

  generate
    if (HAS_FAST) begin : g_fast
      assign in_fast = fast_en &&
                       (((a_x >= FLO_LO) && (a_x <= FLO_HI)) || (a_x >= FHI_LO));
    end else begin : g_nofast
      logic unused_en;
      assign unused_en = fast_en;
      assign in_fast   = 1'b0;
    end
  endgenerate

  always_comb begin
    if (in_rom)       region = REG_ROM;
    else if (in_ram)  region = REG_RAM;
    else if (in_fast) region = REG_FAST;
    else              region = REG_EXT;
  end
endmodule

// File: rtl/wnb_seq.sv
module wnb_seq
  import wnb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BYTE_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:1] word_addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW/2-1:0] ext_rdata,
  output logic          idle,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ext_addr,
  output logic [DW/2-1:0] ext_wdata,
  output logic          ext_rd,
  output logic          ext_wr,
  output logic [DW-1:0] hold
);
  localparam int BW = DW / 2;
  localparam int CW = $clog2(BYTE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_CLKS - 1);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [AW-1:1] addr_q;
  logic [DW-1:0] data_q;
  logic          we_q;
  logic          lane_hi;
  logic          last_clk;

  assign idle     = (phase == PH_IDLE);
  assign done     = (phase == PH_DONE);
  assign busy     = (phase == PH_LO) || (phase == PH_HI);
  assign lane_hi  = (phase == PH_HI);
  assign last_clk = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      we_q  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          addr_q <= word_addr;
          data_q <= wdata;
          we_q   <= we;
          cnt    <= '0;
          phase  <= PH_LO;
        end
        PH_LO: if (cnt == LAST) begin
          cnt   <= '0;
          phase <= PH_HI;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_HI: if (cnt == LAST) begin
          cnt   <= '0;
          phase <= PH_DONE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // one capture register per byte lane, each loaded at the end of its own cycle
  generate
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      always_ff @(posedge clk) begin
        if (last_clk && !we_q && (lane_hi == (ln == 1)))
          hold[ln*BW +: BW] <= ext_rdata;
      end
    end
  endgenerate

  assign ext_addr  = busy ? {addr_q, ~lane_hi} : '0;
  assign ext_wdata = (busy && we_q) ? (lane_hi ? data_q[DW-1:BW] : data_q[BW-1:0]) : '0;
  assign ext_rd    = busy && !we_q;
  assign ext_wr    = busy && we_q;

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));

  a_r3_high_follows_low: assert property (@(posedge clk) disable iff (rst)
    (busy && !ext_addr[0]) |-> $past(busy));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ext_addr[AW-1:1]));

  a_r1_done_after_high: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !$past(ext_addr[0])));
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge
  import wnb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BYTE_CLKS = 3,
  parameter int RAM_BASE  = 'h8300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fast_en,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_wait,
  output logic [DW-1:0] cpu_rdata,
  output logic [1:0]    fast_sel,
  output logic          fast_we,
  input  logic [DW-1:0] fast_rdata,
  output logic [AW-1:0] ext_addr,
  output logic [DW/2-1:0] ext_wdata,
  output logic          ext_rd,
  output logic          ext_wr,
  input  logic [DW/2-1:0] ext_rdata
);
  region_e       region;
  logic          idle, busy, done;
  logic          start;
  logic [DW-1:0] hold;
  logic          is_fast;

  wnb_decode #(
    .AW       (AW),
    .RAM_BASE (RAM_BASE)
  ) u_decode (
    .addr    (cpu_addr),
    .fast_en (fast_en),
    .region  (region)
  );

  assign is_fast = (region != REG_EXT);
  assign start   = cpu_valid && idle && !is_fast;

  wnb_seq #(
    .AW        (AW),
    .DW        (DW),
    .BYTE_CLKS (BYTE_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .we        (cpu_we),
    .word_addr (cpu_addr[AW-1:1]),
    .wdata     (cpu_wdata),
    .ext_rdata (ext_rdata),
    .idle      (idle),
    .busy      (busy),
    .done      (done),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .hold      (hold)
  );

  assign cpu_wait  = busy || start;
  assign fast_sel  = (cpu_valid && idle) ? region : REG_EXT;
  assign fast_we   = cpu_valid && idle && is_fast && cpu_we;
  assign cpu_rdata = done ? hold : fast_rdata;

  a_r5_wait_over_strobes: assert property (@(posedge clk) disable iff (rst)
    (ext_rd || ext_wr) |-> cpu_wait);

  a_r5_release_after_seq: assert property (@(posedge clk) disable iff (rst)
    ($past(ext_rd || ext_wr) && !(ext_rd || ext_wr)) |-> !cpu_wait);

  a_r6_fast_no_wait: assert property (@(posedge clk) disable iff (rst)
    (fast_sel != 2'd0) |-> (!cpu_wait && !ext_rd && !ext_wr));

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ext_rd && !ext_wr));
endmodule

// File: tb/wide_narrow_bridge_bench.sv
module wide_narrow_bridge_bench;
  localparam int B = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_en = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_wait;
  logic [15:0] cpu_rdata;
  logic [1:0]  fast_sel;
  logic        fast_we;
  logic [15:0] fast_rdata;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_rd, ext_wr;
  logic [7:0]  ext_rdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] periph(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign ext_rdata  = periph(ext_addr);
  assign fast_rdata = {cpu_addr[7:0], cpu_addr[15:8]} ^ 16'hA5C3;

  wide_narrow_bridge #(.BYTE_CLKS(B)) u_wide_narrow_bridge (
    .clk(clk), .rst(rst), .fast_en(fast_en),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
    .fast_sel(fast_sel), .fast_we(fast_we), .fast_rdata(fast_rdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_rdata(ext_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [1:0] exp_region(input logic [15:0] a, input logic fe);
    if (a < 16'h2000) return 2'd1;
    if (a[15:8] == 8'h83) return 2'd2;
    if (fe && ((a >= 16'h2000 && a <= 16'h3FFF) || a >= 16'hA000)) return 2'd3;
    return 2'd0;
  endfunction

  task automatic access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                        input logic fe);
    logic [1:0]  rg;
    logic [15:0] exp_rd;
    rg = exp_region(a, fe);
    @(negedge clk);
    fast_en = fe; cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    if (rg != 2'd0) begin
      chk(fast_sel == rg, (rg == 2'd1) ? "R6 sel" : (rg == 2'd2) ? "R7 sel" : "R8 sel",
          32'(fast_sel), 32'(rg));
      chk(!cpu_wait && !ext_rd && !ext_wr, "R6 no wait/strobe",
          {cpu_wait, ext_rd, ext_wr}, 0);
      chk(fast_we == we, "R6 fast_we", 32'(fast_we), 32'(we));
      if (!we) chk(cpu_rdata == fast_rdata, "R6 rdata", 32'(cpu_rdata), 32'(fast_rdata));
    end else begin
      exp_rd = {periph({a[15:1], 1'b0}), periph({a[15:1], 1'b1})};
      for (int k = 0; k <= 2*B + 1; k++) begin
        if (k > 0) begin
          @(negedge clk);
          if (k == 1) begin  // R9: scramble processor bus during wait
            cpu_addr = ~a; cpu_wdata = ~wd; cpu_we = ~we;
          end
          #1;
        end
        chk(cpu_wait == (k <= 2*B), "R5 wait", 32'(cpu_wait), 32'(k <= 2*B));
        chk(fast_sel == 2'd0, "R8 sel ext", 32'(fast_sel), 0);
        if (k >= 1 && k <= 2*B) begin
          chk(ext_rd == !we && ext_wr == we, "R4 strobe", {ext_rd, ext_wr}, {!we, we});
          chk(ext_addr == {a[15:1], (k <= B)}, "R3 ext_addr R9",
              32'(ext_addr), 32'({a[15:1], (k <= B)}));
          if (we)
            chk(ext_wdata == ((k <= B) ? wd[7:0] : wd[15:8]), "R2 wdata",
                32'(ext_wdata), 32'((k <= B) ? wd[7:0] : wd[15:8]));
        end else begin
          chk(!ext_rd && !ext_wr && ext_addr == 16'h0, "R4 idle strobes",
              {ext_rd, ext_wr, ext_addr}, 0);
        end
        if (k == 2*B + 1 && !we)
          chk(cpu_rdata == exp_rd, "R1 rdata", 32'(cpu_rdata), 32'(exp_rd));
      end
    end
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<200000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!cpu_wait && !ext_rd && !ext_wr && fast_sel == 2'd0, "R10 reset",
        {cpu_wait, ext_rd, ext_wr, fast_sel}, 0);

    for (int fe = 0; fe < 2; fe++) begin
      for (int i = 0; i < 64; i++) begin
        logic [15:0] a;
        a = 16'(i * 16'h0400 + (i % 5) * 16'h0046);
        access(1'b0, a, 16'h0, fe[0]);
        access(1'b1, a, 16'(i * 16'h1357 + 16'h0A0B), fe[0]);
      end
      // region boundaries: R6 R7 R8
      access(1'b0, 16'h1FFE, 16'h0, fe[0]);
      access(1'b0, 16'h2000, 16'h0, fe[0]);
      access(1'b0, 16'h3FFE, 16'h0, fe[0]);
      access(1'b0, 16'h4000, 16'h0, fe[0]);
      access(1'b1, 16'h82FE, 16'hBEEF, fe[0]);
      access(1'b1, 16'h8300, 16'h1234, fe[0]);
      access(1'b0, 16'h83FE, 16'h0, fe[0]);
      access(1'b0, 16'h8400, 16'h0, fe[0]);
      access(1'b0, 16'h9FFE, 16'h0, fe[0]);
      access(1'b1, 16'hA000, 16'h5AA5, fe[0]);
      access(1'b0, 16'hFFFE, 16'h0, fe[0]);
    end

    // mid-run reset returns to idle (R10)
    @(negedge clk);
    fast_en = 1'b0; cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h6000;
    repeat (2) @(negedge clk);
    cpu_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!cpu_wait && !ext_rd && !ext_wr, "R10 reset mid-access",
        {cpu_wait, ext_rd, ext_wr}, 0);
    access(1'b0, 16'h6002, 16'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule